// File: doc/BRIEF.md
# Flash Command State Machine

This block is the control core of a byte-wide, sector-erasable flash memory that sits on a parallel bus with active-low chip select, write strobe and read strobe. Software reaches the storage only through command writes. A short unlock prefix followed by an opcode starts a byte program, a sector erase or a whole-array erase. Each bus write captures its address and data. Once started, the operation runs on its own for a configurable number of clock cycles. While it runs, a read returns a status byte instead of array data. Bit 7 of that byte carries a polarity flag and bit 6 flips on every read. When the operation ends, the block returns to normal reads without further commands.

The storage is a synthesizable byte array. Its size is set by the address width, and the top three address bits always select one of eight equal sectors. The full-size part uses a 19-bit address. The default build uses 11 bits so that elaboration stays small.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The array starts with every byte at 0xFF. `dq_oe` is high only in the cycle after one in which `ce_n` and `oe_n` are low and `we_n` is high. When idle, `dq_out` shows the byte at `addr` two cycles after the address is presented.
- R2: The write sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data D at address A programs byte A to (old value AND D). Only the low 11 address bits are compared for the key addresses. The data write may carry any value, including 0xF0.
- R3: While busy, a read returns a status byte. Bits 5:0 are zero. Bit 7 is the inverse of bit 7 of the programmed data during a program, and 0 during either erase.
- R4: Status bit 6 is 0 after reset and inverts on each read that starts while busy. It does not change on reads made while idle.
- R5: The write sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30 at any address in a sector erases that sector. The sector is chosen by the top 3 address bits. Every byte of the sector is first cleared to 0x00 and then set to 0xFF. Bytes outside the sector are unchanged.
- R6: The same five-write prefix followed by 0x10@0x555 sets every byte of the array to 0xFF.
- R7: When a program or erase finishes, reads return array data again, and a new command sequence is accepted with no reset command.
- R8: A write of 0xF0 in any command cycle (not the program data cycle) returns the sequencer to idle, and the partial sequence is discarded.
- R9: Any write whose address or data differs from the next expected step returns the sequencer to idle, and no operation starts.
- R10: While `vlow` is high, no operation can start. A partial sequence that is pending when `vlow` rises is discarded.
- R11: Bus writes made while an operation is busy are ignored. They neither start a second operation nor advance the sequencer.
- R12: A bus write is taken on the clock where `we_n` is sampled low after being high while `ce_n` is low. The address and data are captured in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from the bus |
| vlow | input | 1 | Supply-low indication, blocks operation starts |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Enables the external data driver |

## Verification
The hardest cases to reach are those where a command arrives in the middle of something else. One is a write sequence that lands while an operation is still running. Another is a supply-low pulse that falls between two unlock writes. The bench starts a long program and then issues a full second program sequence inside the busy window. It also raises `vlow` for a few cycles between the second unlock write and the opcode. In both cases it reads back bytes whose values would have changed if the stray sequence had been accepted. The toggle bit is checked against a model that counts only the reads the bench knows fall inside the busy window.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
  localparam int KEY_W = 11;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_ABORT  = 8'hF0;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_K1, SEQ_K2, SEQ_PDATA, SEQ_E1, SEQ_E2, SEQ_E3
  } seq_e;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PGM, PH_PRE, PH_ERW, PH_FILL
  } phase_e;
endpackage

// File: rtl/fcsm_bus_port.sv
module fcsm_bus_port #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_stb
);
  logic we_prev, oe_prev;
  logic wr_edge;

  assign wr_edge = !ce_n && we_prev && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev <= 1'b1;
      oe_prev <= 1'b1;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_prev <= we_n;
      oe_prev <= oe_n;
      wr_stb  <= wr_edge;
      rd_stb  <= !ce_n && we_n && oe_prev && !oe_n;
      if (wr_edge) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end
endmodule

// File: rtl/fcsm_cmd_seq.sv
module fcsm_cmd_seq
  import fcsm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              vlow,
  output logic              start,
  output op_e               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  seq_e seq_q;
  logic key_a, key_b, blocked;

  assign key_a   = (wr_addr[KEY_W-1:0] == KEY_ADDR_A);
  assign key_b   = (wr_addr[KEY_W-1:0] == KEY_ADDR_B);
  assign blocked = busy || start;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= SEQ_IDLE;
      start   <= 1'b0;
      op_kind <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      start <= 1'b0;
      if (vlow) begin
        seq_q <= SEQ_IDLE;
      end else if (wr_stb && !blocked) begin
        seq_q <= SEQ_IDLE;
        if (seq_q == SEQ_PDATA) begin
          start   <= 1'b1;
          op_kind <= OP_PROG;
          op_addr <= wr_addr;
          op_data <= wr_data;
        end else if (wr_data != CMD_ABORT) begin
          case (seq_q)
            SEQ_IDLE: if (key_a && wr_data == CMD_KEY_A) seq_q <= SEQ_K1;
            SEQ_K1:   if (key_b && wr_data == CMD_KEY_B) seq_q <= SEQ_K2;
            SEQ_K2: begin
              if (key_a && wr_data == CMD_PROG)  seq_q <= SEQ_PDATA;
              if (key_a && wr_data == CMD_ERASE) seq_q <= SEQ_E1;
            end
            SEQ_E1:   if (key_a && wr_data == CMD_KEY_A) seq_q <= SEQ_E2;
            SEQ_E2:   if (key_b && wr_data == CMD_KEY_B) seq_q <= SEQ_E3;
            SEQ_E3: begin
              if (wr_data == CMD_SECTOR) begin
                start   <= 1'b1;
                op_kind <= OP_SECT;
                op_addr <= wr_addr;
                op_data <= 8'hFF;
              end else if (key_a && wr_data == CMD_CHIP) begin
                start   <= 1'b1;
                op_kind <= OP_CHIP;
                op_addr <= '0;
                op_data <= 8'hFF;
              end
            end
            default: seq_q <= SEQ_IDLE;
          endcase
        end
      end
    end
  end

  // R10: a supply-low cycle never lets an operation start on the next edge
  assert_vlow_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    vlow |=> !start);

  // R11: while the engine runs the sequencer holds in idle
  assert_idle_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (seq_q == SEQ_IDLE));
endmodule

// File: rtl/fcsm_op_engine.sv
module fcsm_op_engine
  import fcsm_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECT_BITS    = 3,
  parameter int PROG_CYCLES  = 64,
  parameter int ERASE_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_e               op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [7:0]        mem_q,
  output logic              busy,
  output logic              poll7,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  localparam int OFS_W      = ADDR_W - SECT_BITS;
  localparam int PROG_LOAD  = (PROG_CYCLES < 2) ? 1 : PROG_CYCLES - 1;
  localparam int ERASE_LOAD = (ERASE_CYCLES < 1) ? 0 : ERASE_CYCLES - 1;
  localparam int CNT_MAX    = (PROG_LOAD > ERASE_LOAD) ? PROG_LOAD : ERASE_LOAD;
  localparam int CNT_W      = $clog2(CNT_MAX + 2);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  cur_q, base_q, last_q;
  logic [7:0]         data_q;
  logic               poll_q;
  logic [ADDR_W-1:0]  sect_base, sect_last;

  assign sect_base = {op_addr[ADDR_W-1 -: SECT_BITS], {OFS_W{1'b0}}};
  assign sect_last = {op_addr[ADDR_W-1 -: SECT_BITS], {OFS_W{1'b1}}};

  assign busy     = (phase_q != PH_IDLE);
  assign poll7    = poll_q;
  assign eng_addr = cur_q;

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 8'hFF;
    case (phase_q)
      PH_PGM: begin
        mem_we    = (cnt_q == '0);
        mem_wdata = mem_q & data_q;
      end
      PH_PRE: begin
        mem_we    = 1'b1;
        mem_wdata = 8'h00;
      end
      PH_FILL: begin
        mem_we    = 1'b1;
        mem_wdata = 8'hFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      base_q  <= '0;
      last_q  <= '0;
      data_q  <= '0;
      poll_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          data_q <= op_data;
          case (op_kind)
            OP_PROG: begin
              phase_q <= PH_PGM;
              cnt_q   <= CNT_W'(PROG_LOAD);
              cur_q   <= op_addr;
              poll_q  <= ~op_data[7];
            end
            OP_SECT: begin
              phase_q <= PH_PRE;
              cur_q   <= sect_base;
              base_q  <= sect_base;
              last_q  <= sect_last;
              poll_q  <= 1'b0;
            end
            default: begin
              phase_q <= PH_PRE;
              cur_q   <= '0;
              base_q  <= '0;
              last_q  <= '1;
              poll_q  <= 1'b0;
            end
          endcase
        end
        PH_PGM: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_PRE: begin
          if (cur_q == last_q) begin
            phase_q <= PH_ERW;
            cnt_q   <= CNT_W'(ERASE_LOAD);
            cur_q   <= base_q;
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        PH_ERW: begin
          if (cnt_q == '0) phase_q <= PH_FILL;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_FILL: begin
          if (cur_q == last_q) phase_q <= PH_IDLE;
          else                 cur_q   <= cur_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R7: an accepted start always makes the engine busy on the next edge
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R5: erase passes never write outside the chosen range
  assert_erase_range_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && phase_q != PH_PGM) |-> (cur_q >= base_q && cur_q <= last_q));
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcsm_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECT_BITS    = 3,
  parameter int PROG_CYCLES  = 64,
  parameter int ERASE_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              vlow,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  logic              wr_stb, rd_stb;
  logic [ADDR_W-1:0] wr_addr, op_addr, eng_addr, rd_addr;
  logic [7:0]        wr_data, op_data, mem_q, mem_wdata;
  logic              start, busy, poll7, mem_we;
  op_e               op_kind;
  logic              tog_q;

  fcsm_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb)
  );

  fcsm_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .vlow(vlow), .start(start),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  fcsm_op_engine #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .mem_q(mem_q), .busy(busy),
    .poll7(poll7), .eng_addr(eng_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  assign rd_addr = busy ? eng_addr : addr;

  fcsm_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(eng_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q  <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      if (rd_stb && busy) tog_q <= ~tog_q;
      dq_oe  <= !ce_n && !oe_n && we_n;
      dq_out <= busy ? {poll7, tog_q, 6'b0} : mem_q;
    end
  end

  // R1: with the chip deselected the data driver stays off
  assert_no_drive_R1: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n) |-> !dq_oe);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int AW = 11;
  localparam int PC = 60;
  localparam int EC = 50;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dq_out;
  logic dq_oe;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .SECT_BITS(3), .PROG_CYCLES(PC), .ERASE_CYCLES(EC))
    u_flash_cmd_ctrl (
      .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(din), .vlow(vlow), .dq_out(dq_out), .dq_oe(dq_oe));

  int checks = 0, fails = 0;
  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic mon_req = 1'b0;
  logic [7:0] shadow [1<<AW];
  bit tog_m = 1'b0;

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops the scoreboard when a read is sampled
  always @(negedge clk) begin
    if (mon_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", dq_out, 8'h00);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(dq_out === e.val, e.tag, dq_out, e.val);
        chk(dq_oe === 1'b1, "R1 dq_oe during read", {7'b0, dq_oe}, 8'h01);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [7:0] d);
    tick(1);
    addr = a; din = d; ce_n = 1'b0;
    tick(1); we_n = 1'b0;
    tick(1); we_n = 1'b1; ce_n = 1'b1;
    tick(1);
  endtask

  task automatic bus_rd(logic [AW-1:0] a, logic [7:0] exp, string tag);
    tick(1);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(4);
    exp_q.push_back('{exp, tag});
    mon_req = 1'b1;
    tick(1);
    mon_req = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
    tick(1);
  endtask

  task automatic rd_true(logic [AW-1:0] a, string tag);
    bus_rd(a, shadow[a], tag);
  endtask

  task automatic rd_status(bit d7_final, string tag);
    tog_m = ~tog_m;
    bus_rd('0, {~d7_final, tog_m, 6'b0}, tag);
  endtask

  task automatic unlock();
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d, bit status);
    unlock();
    bus_wr(11'h555, 8'hA0);
    bus_wr(a, d);
    shadow[a] = shadow[a] & d;
    if (status) begin
      rd_status(d[7], "R3 program polling");
      rd_status(d[7], "R4 toggle second read");
    end
    tick(PC + 20);
  endtask

  task automatic erase_prefix();
    unlock();
    bus_wr(11'h555, 8'h80);
    unlock();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 8'h00, 8'h01);
    report();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = 8'hFF;
    tick(4);
    rst = 1'b0;
    tick(2);
    chk(dq_oe === 1'b0, "R1 reset dq_oe", {7'b0, dq_oe}, 8'h00);
    rd_true(11'h000, "R1 erased after reset");
    rd_true(11'h7FF, "R1 erased top byte");

    // R12, R2, R3, R4: program and poll
    prog(11'h123, 8'h3C, 1'b1);
    rd_true(11'h123, "R2 program value");
    rd_true(11'h123, "R4 no toggle when idle");
    prog(11'h123, 8'hF5, 1'b1);
    rd_true(11'h123, "R2 program ANDs old value");
    prog(11'h410, 8'h5A, 1'b0);
    prog(11'h7FF, 8'h77, 1'b0);
    prog(11'h000, 8'h11, 1'b0);
    prog(11'h500, 8'hF0, 1'b0);
    rd_true(11'h500, "R2 data cycle accepts F0");
    rd_true(11'h7FF, "R7 back to read after program");

    // R1: write strobe low blocks the driver
    tick(1); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 11'h040; din = 8'h00;
    tick(3);
    chk(dq_oe === 1'b0, "R1 no drive while writing", {7'b0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    tick(2);

    // R5: sector erase of sector 1
    erase_prefix();
    bus_wr(11'h1A7, 8'h30);
    for (int i = 11'h100; i <= 11'h1FF; i++) shadow[i] = 8'hFF;
    rd_status(1'b1, "R3 erase polling");
    rd_status(1'b1, "R4 toggle during erase");
    tick(700);
    rd_true(11'h123, "R5 sector byte erased");
    rd_true(11'h100, "R5 sector first byte");
    rd_true(11'h410, "R5 other sector kept");
    rd_true(11'h000, "R5 lower sector kept");
    rd_true(11'h7FF, "R5 top sector kept");

    // R9: wrong address on opcode
    unlock();
    bus_wr(11'h123, 8'hA0);
    bus_wr(11'h410, 8'h00);
    tick(PC + 20);
    rd_true(11'h410, "R9 deviating sequence ignored");

    // R8: abort mid-sequence
    unlock();
    bus_wr(11'h000, 8'hF0);
    bus_wr(11'h555, 8'hA0);
    bus_wr(11'h410, 8'h00);
    tick(PC + 20);
    rd_true(11'h410, "R8 abort discards sequence");

    // R10: supply low blocks a full sequence
    vlow = 1'b1;
    unlock();
    bus_wr(11'h555, 8'hA0);
    bus_wr(11'h7FF, 8'h00);
    vlow = 1'b0;
    tick(PC + 20);
    rd_true(11'h7FF, "R10 blocked while low");

    // R10: supply low pulse aborts pending prefix
    unlock();
    vlow = 1'b1; tick(3); vlow = 1'b0;
    bus_wr(11'h555, 8'hA0);
    bus_wr(11'h7FF, 8'h00);
    tick(PC + 20);
    rd_true(11'h7FF, "R10 pending prefix aborted");

    // R11: full sequence during busy is ignored
    unlock();
    bus_wr(11'h555, 8'hA0);
    bus_wr(11'h200, 8'h0F);
    shadow[11'h200] = 8'h0F;
    prog(11'h300, 8'h00, 1'b0);
    shadow[11'h300] = 8'hFF;
    tick(PC + 20);
    rd_true(11'h200, "R11 first program done");
    rd_true(11'h300, "R11 write during busy ignored");

    // R6: chip erase
    erase_prefix();
    bus_wr(11'h555, 8'h10);
    for (int i = 0; i < (1<<AW); i++) shadow[i] = 8'hFF;
    tick(4400);
    rd_true(11'h000, "R6 chip erase low");
    rd_true(11'h410, "R6 chip erase mid");
    rd_true(11'h7FF, "R6 chip erase top");
    rd_true(11'h200, "R6 chip erase other");

    // R7: new command accepted right after an erase
    prog(11'h655, 8'h81, 1'b1);
    rd_true(11'h655, "R7 program after erase");

    tick(4);
    chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    report();
  end
endmodule